// File: doc/BRIEF.md
# Three-Valued Logic Operation Unit

This block evaluates one logic operation on two operands whose bits may be unknown. Each operand arrives as a pair of vectors: a value vector and an unknown-mask vector. Where a mask bit is set, that position is treated as unknown and its value bit plays no part. Inside the block every position is spread onto three exclusive wires meaning "is zero", "is one" and "is unknown". The operation is carried out on those wires using only ordinary two-valued gates, and the result is folded back into value/mask form.

The result is as precise as bitwise reasoning allows. An unknown input only makes the output unknown when a defined input cannot settle it. For example, a defined zero on one side of an AND gives zero whatever the other side holds. An opcode picks the operation: bitwise, reduction, logical, equality, inequality or exact match. Operand B may be narrower than A. Its missing upper positions count as defined zeros. The block has no clock and no state. It suits a simulation accelerator or a formal model that has to carry unknowns through logic held in two-valued form.

Top module: `xtl_unit`

## Requirements
- R1: An input value bit under a set mask bit has no effect on the result. An output value bit is 0 wherever its output mask bit is 1.
- R2: Opcode 0 (AND) is bitwise. A defined 0 on either side gives 0, defined 1 on both sides gives 1, and anything else gives unknown. Opcode 1 (OR) is the dual: a defined 1 on either side gives 1, defined 0 on both gives 0, and anything else gives unknown.
- R3: Opcode 2 (XOR) and opcode 3 (XNOR) are bitwise. A position is unknown exactly when either input position is unknown. Otherwise it holds the exclusive-or, or its complement for XNOR.
- R4: Opcodes 4 (reduce-AND) and 5 (reduce-OR) act on A alone. For reduce-AND, any defined 0 gives 0, all ones gives 1, and anything else gives unknown. Reduce-OR is the dual. Every opcode from 4 to 11 writes its result to bit 0 only, and output bits above 0 are defined 0.
- R5: Opcode 6 (reduce-XOR) on A is unknown if any bit of A is unknown. Otherwise it is the parity of A.
- R6: Opcodes 7 (logical AND) and 8 (logical OR) first reduce each operand to a truth value. The truth value is 1 if any bit is a defined 1, 0 if every bit is a defined 0, and unknown otherwise. These truth values are then combined with the AND or OR rule of R2.
- R7: Opcode 9 (equal) gives 0 if some position differs with both sides defined. Failing that, it gives unknown if any position is unknown on either side, and 1 otherwise. Opcode 10 (not equal) swaps the defined results.
- R8: Opcode 11 (exact match) gives 1 when every position has the same three-valued state on both sides, unknown matching unknown, and 0 otherwise. It is never unknown.
- R9: Operand B of width BW is widened to W with defined zeros before any opcode that uses it.
- R10: Opcodes 12 to 15 give unknown in every output position.
- R11: Output `enc_ok` is 1 whenever every internal position, on both inputs and output, has exactly one of its three wires high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_val | input | W | Operand A value bits |
| a_xm | input | W | Operand A unknown mask (1 = unknown) |
| b_val | input | BW | Operand B value bits |
| b_xm | input | BW | Operand B unknown mask (1 = unknown) |
| op | input | 4 | Operation select, codes as listed in R2 to R10 |
| y_val | output | W | Result value bits |
| y_xm | output | W | Result unknown mask |
| enc_ok | output | 1 | Three-wire encoding consistency flag |

## Verification
Directed vectors isolate each deciding case. These include a defined 0 against an unknown for AND, a defined 1 against an unknown for OR, and a definite mismatch next to an unknown for equality, which must give 0 rather than unknown. They also include matching unknowns for exact match and all-unknown or all-defined operands for the reductions. Pairs of vectors that differ only in value bits under the mask show that masked data is ignored. A vector with ones in A above the width of B shows the zero widening. A long run of pseudo-random operands with sparse and dense masks, swept over every opcode, tells apart rail formulas that agree only on fully defined data.

// File: rtl/xtl_pkg.sv
package xtl_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_XNOR = 4'd3,
    OP_RAND = 4'd4,
    OP_ROR  = 4'd5,
    OP_RXOR = 4'd6,
    OP_LAND = 4'd7,
    OP_LOR  = 4'd8,
    OP_EQ   = 4'd9,
    OP_NE   = 4'd10,
    OP_CEQ  = 4'd11
  } xtl_op_e;

  // One three-valued position on its three wires.
  typedef struct packed {
    logic z;
    logic o;
    logic x;
  } tri_t;

  // Opcodes whose result sits in bit 0 only.
  function automatic logic op_is_bool(input logic [3:0] code);
    return (code >= 4'd4) && (code <= 4'd11);
  endfunction

  // Build a position from its zero and one wires; unknown fills the gap.
  function automatic tri_t settle(input logic zero, input logic one);
    tri_t t;
    t.z = zero;
    t.o = one;
    t.x = ~(zero | one);
    return t;
  endfunction

  // Exchange the defined results (used for duals and complements).
  function automatic tri_t flip(input tri_t t);
    tri_t r;
    r.z = t.o;
    r.o = t.z;
    r.x = t.x;
    return r;
  endfunction

endpackage

// File: rtl/xtl_split.sv
module xtl_split #(
  parameter int IW = 8,
  parameter int OW = 8
) (
  input  logic [IW-1:0] val,
  input  logic [IW-1:0] xm,
  output logic [OW-1:0] is0,
  output logic [OW-1:0] is1,
  output logic [OW-1:0] isx,
  output logic          ok
);
  localparam int PAD = OW - IW;

  for (genvar i = 0; i < OW; i++) begin : g_bit
    if (i < IW) begin : g_live
      assign is1[i] = val[i] & ~xm[i];
      assign is0[i] = ~val[i] & ~xm[i];
      assign isx[i] = xm[i];
    end else begin : g_pad
      assign is1[i] = 1'b0;
      assign is0[i] = 1'b1;
      assign isx[i] = 1'b0;
    end
  end

  assign ok = (&(is0 | is1 | isx)) & ~(|((is0 & is1) | (is0 & isx) | (is1 & isx)));

  always_comb begin
    if (PAD >= 0) begin
      for (int k = 0; k < OW; k++)
        a_r11_split_onehot: assert ($countones({is0[k], is1[k], isx[k]}) == 1)
          else $error("R11 split rails not one-hot at %0d", k);
    end
  end
endmodule

// File: rtl/xtl_ops.sv
module xtl_ops
  import xtl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a0,
  input  logic [W-1:0] a1,
  input  logic [W-1:0] ax,
  input  logic [W-1:0] b0,
  input  logic [W-1:0] b1,
  input  logic [W-1:0] bx,
  input  xtl_op_e      op,
  output logic [W-1:0] y0,
  output logic [W-1:0] y1,
  output logic [W-1:0] yx
);
  // Shared intermediate events, named for inspection.
  logic [W-1:0] xor_x, xor_o, eq_diff, eq_xpos;
  tri_t red_and, red_or, red_xor, a_truth, b_truth, land_r, lor_r, eq_r, ceq_r;

  assign xor_x   = ax | bx;
  assign xor_o   = (a1 ^ b1) & ~xor_x;
  assign eq_xpos = ax | bx;
  assign eq_diff = (a1 ^ b1) & ~eq_xpos;

  assign red_and = settle(|a0, &a1);
  assign red_or  = settle(&a0, |a1);
  assign a_truth = settle(&a0, |a1);
  assign b_truth = settle(&b0, |b1);
  assign land_r  = settle(a_truth.z | b_truth.z, a_truth.o & b_truth.o);
  assign lor_r   = settle(a_truth.z & b_truth.z, a_truth.o | b_truth.o);

  always_comb begin
    red_xor.x = |ax;
    red_xor.o = (^a1) & ~red_xor.x;
    red_xor.z = ~(red_xor.o | red_xor.x);
    eq_r.z    = |eq_diff;
    eq_r.x    = (|eq_xpos) & ~eq_r.z;
    eq_r.o    = ~(eq_r.z | eq_r.x);
    ceq_r.o   = &(~(a0 ^ b0) & ~(a1 ^ b1));
    ceq_r.z   = ~ceq_r.o;
    ceq_r.x   = 1'b0;
  end

  function automatic void put_bool(input tri_t t,
                                   output logic [W-1:0] z,
                                   output logic [W-1:0] o,
                                   output logic [W-1:0] x);
    z = {{(W-1){1'b1}}, t.z};
    o = {{(W-1){1'b0}}, t.o};
    x = {{(W-1){1'b0}}, t.x};
  endfunction

  always_comb begin
    y0 = '0;
    y1 = '0;
    yx = '1;
    unique case (op)
      OP_AND: begin
        y0 = a0 | b0;
        y1 = a1 & b1;
        yx = ~(y0 | y1);
      end
      OP_OR: begin
        y1 = a1 | b1;
        y0 = a0 & b0;
        yx = ~(y0 | y1);
      end
      OP_XOR: begin
        yx = xor_x;
        y1 = xor_o;
        y0 = ~(xor_o | xor_x);
      end
      OP_XNOR: begin
        yx = xor_x;
        y0 = xor_o;
        y1 = ~(xor_o | xor_x);
      end
      OP_RAND: put_bool(red_and, y0, y1, yx);
      OP_ROR:  put_bool(red_or, y0, y1, yx);
      OP_RXOR: put_bool(red_xor, y0, y1, yx);
      OP_LAND: put_bool(land_r, y0, y1, yx);
      OP_LOR:  put_bool(lor_r, y0, y1, yx);
      OP_EQ:   put_bool(eq_r, y0, y1, yx);
      OP_NE:   put_bool(flip(eq_r), y0, y1, yx);
      OP_CEQ:  put_bool(ceq_r, y0, y1, yx);
      default: begin
        y0 = '0;
        y1 = '0;
        yx = '1;
      end
    endcase
  end
endmodule

// File: rtl/xtl_merge.sv
module xtl_merge #(
  parameter int W = 8
) (
  input  logic [W-1:0] is0,
  input  logic [W-1:0] is1,
  input  logic [W-1:0] isx,
  output logic [W-1:0] val,
  output logic [W-1:0] xm,
  output logic         ok
);
  assign val = is1 & ~isx;
  assign xm  = isx;
  assign ok  = (&(is0 | is1 | isx)) & ~(|((is0 & is1) | (is0 & isx) | (is1 & isx)));

  always_comb begin
    for (int k = 0; k < W; k++)
      a_r11_merge_onehot: assert ($countones({is0[k], is1[k], isx[k]}) == 1)
        else $error("R11 result rails not one-hot at %0d", k);
  end
endmodule

// File: rtl/xtl_unit.sv
module xtl_unit
  import xtl_pkg::*;
#(
  parameter int W  = 8,
  parameter int BW = 8
) (
  input  logic [W-1:0]  a_val,
  input  logic [W-1:0]  a_xm,
  input  logic [BW-1:0] b_val,
  input  logic [BW-1:0] b_xm,
  input  logic [3:0]    op,
  output logic [W-1:0]  y_val,
  output logic [W-1:0]  y_xm,
  output logic          enc_ok
);
  logic [W-1:0] a0, a1, ax, b0, b1, bx, y0, y1, yx;
  logic         ok_a, ok_b, ok_y;
  xtl_op_e      op_e;

  assign op_e = xtl_op_e'(op);

  xtl_split #(.IW(W), .OW(W)) u_split_a (
    .val(a_val), .xm(a_xm), .is0(a0), .is1(a1), .isx(ax), .ok(ok_a)
  );

  xtl_split #(.IW(BW), .OW(W)) u_split_b (
    .val(b_val), .xm(b_xm), .is0(b0), .is1(b1), .isx(bx), .ok(ok_b)
  );

  xtl_ops #(.W(W)) u_ops (
    .a0(a0), .a1(a1), .ax(ax), .b0(b0), .b1(b1), .bx(bx),
    .op(op_e), .y0(y0), .y1(y1), .yx(yx)
  );

  xtl_merge #(.W(W)) u_merge (
    .is0(y0), .is1(y1), .isx(yx), .val(y_val), .xm(y_xm), .ok(ok_y)
  );

  assign enc_ok = ok_a & ok_b & ok_y;

  // Port-level checks.
  logic [W-1:0] b_xm_wide;
  assign b_xm_wide = W'(b_xm);

  always_comb begin
    a_r1_masked_data_zero: assert ((y_val & y_xm) == '0)
      else $error("R1 value bit set under mask");
    if (op_is_bool(op)) begin
      a_r4_bool_upper_defined: assert ((y_val[W-1:1] == '0) && (y_xm[W-1:1] == '0))
        else $error("R4 upper result bits not defined zero");
    end
    if (op == 4'd11) begin
      a_r8_caseeq_never_x: assert (!y_xm[0])
        else $error("R8 exact match produced unknown");
    end
    if (op == 4'd2 || op == 4'd3) begin
      a_r3_xor_x_mask: assert (y_xm == (a_xm | b_xm_wide))
        else $error("R3 xor unknown mask mismatch");
    end
    if (op >= 4'd12) begin
      a_r10_undef_all_x: assert (y_xm == '1)
        else $error("R10 undefined opcode not all unknown");
    end
  end
endmodule

// File: tb/sim_xtl_unit.sv
`timescale 1ns/1ps
module sim_xtl_unit;
  localparam int W  = 8;
  localparam int BW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0]  a_val, a_xm, y_val, y_xm;
  logic [BW-1:0] b_val, b_xm;
  logic [3:0]    op;
  logic          enc_ok;

  xtl_unit #(.W(W), .BW(BW)) u0 (
    .a_val(a_val), .a_xm(a_xm), .b_val(b_val), .b_xm(b_xm),
    .op(op), .y_val(y_val), .y_xm(y_xm), .enc_ok(enc_ok)
  );

  typedef struct {
    logic [W-1:0] ev;
    logic [W-1:0] ex;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // Three-valued position: 0, 1, 2 = unknown.
  function automatic int tv(input logic v, input logic x);
    return x ? 2 : (v ? 1 : 0);
  endfunction

  function automatic int v_and(input int p, input int r);
    if (p == 0 || r == 0) return 0;
    if (p == 1 && r == 1) return 1;
    return 2;
  endfunction

  function automatic int v_or(input int p, input int r);
    if (p == 1 || r == 1) return 1;
    if (p == 0 && r == 0) return 0;
    return 2;
  endfunction

  function automatic int v_not(input int p);
    return (p == 2) ? 2 : 1 - p;
  endfunction

  function automatic string tag_of(input int code);
    case (code)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5:    return "R4";
      6:       return "R5";
      7, 8:    return "R6";
      9, 10:   return "R7";
      11:      return "R8";
      default: return "R10";
    endcase
  endfunction

  // Reference model written position by position.
  function automatic logic [2*W-1:0] model(input int code,
      input logic [W-1:0] av, input logic [W-1:0] ax,
      input logic [BW-1:0] bvn, input logic [BW-1:0] bxn);
    logic [W-1:0] bv, bx, rv, rx;
    int pa[W], pb[W], pr[W];
    int s, ta, tb;
    bit z0, all1, any1, all0, anyx, par, diff, same;
    bv = '0; bx = '0;
    bv[BW-1:0] = bvn; bx[BW-1:0] = bxn;
    anyx = 0; par = 0; diff = 0; same = 1; all1 = 1; any1 = 0; all0 = 1; z0 = 0;
    for (int i = 0; i < W; i++) begin
      pa[i] = tv(av[i], ax[i]);
      pb[i] = tv(bv[i], bx[i]);
      pr[i] = 0;
    end
    for (int i = 0; i < W; i++) begin
      if (pa[i] == 0) z0 = 1;
      if (pa[i] != 1) all1 = 0;
      if (pa[i] == 1) any1 = 1;
      if (pa[i] != 0) all0 = 0;
      if (pa[i] == 2) anyx = 1;
      if (pa[i] == 1) par = ~par;
      if (pa[i] != 2 && pb[i] != 2 && pa[i] != pb[i]) diff = 1;
      if (pa[i] != pb[i]) same = 0;
    end
    ta = any1 ? 1 : (all0 ? 0 : 2);
    begin
      bit bany1, ball0;
      bany1 = 0; ball0 = 1;
      for (int i = 0; i < W; i++) begin
        if (pb[i] == 1) bany1 = 1;
        if (pb[i] != 0) ball0 = 0;
      end
      tb = bany1 ? 1 : (ball0 ? 0 : 2);
    end
    s = 0;
    case (code)
      0: for (int i = 0; i < W; i++) pr[i] = v_and(pa[i], pb[i]);
      1: for (int i = 0; i < W; i++) pr[i] = v_or(pa[i], pb[i]);
      2, 3: for (int i = 0; i < W; i++) begin
        if (pa[i] == 2 || pb[i] == 2) pr[i] = 2;
        else pr[i] = ((pa[i] != pb[i]) ^ (code == 3)) ? 1 : 0;
      end
      4: s = z0 ? 0 : (all1 ? 1 : 2);
      5: s = any1 ? 1 : (all0 ? 0 : 2);
      6: s = anyx ? 2 : (par ? 1 : 0);
      7: s = v_and(ta, tb);
      8: s = v_or(ta, tb);
      9: s = diff ? 0 : (anyx || (bx != '0) ? 2 : 1);
      10: s = v_not(diff ? 0 : (anyx || (bx != '0) ? 2 : 1));
      11: s = same ? 1 : 0;
      default: for (int i = 0; i < W; i++) pr[i] = 2;
    endcase
    if (code >= 4 && code <= 11) pr[0] = s;
    for (int i = 0; i < W; i++) begin
      rv[i] = (pr[i] == 1);
      rx[i] = (pr[i] == 2);
    end
    return {rv, rx};
  endfunction

  task automatic apply(input int code, input logic [W-1:0] av, input logic [W-1:0] ax,
                       input logic [BW-1:0] bvn, input logic [BW-1:0] bxn, input string tag);
    exp_t e;
    logic [2*W-1:0] m;
    @(posedge clk);
    a_val = av; a_xm = ax; b_val = bvn; b_xm = bxn; op = 4'(code);
    m = model(code, av, ax, bvn, bxn);
    e.ev = m[2*W-1:W];
    e.ex = m[W-1:0];
    e.tag = (tag == "") ? tag_of(code) : tag;
    q.push_back(e);
  endtask

  // Monitor: compare away from the driving edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (y_val !== e.ev || y_xm !== e.ex) begin
        fails++;
        $display("FAIL %s op=%0d val=%h/%h exp=%h/%h", e.tag, op, y_val, y_xm, e.ev, e.ex);
      end
      checks++;
      if (enc_ok !== 1'b1) begin
        fails++;
        $display("FAIL R11 enc_ok=%b exp=1", enc_ok);
      end
      checks++;
      if ((y_val & y_xm) != '0) begin
        fails++;
        $display("FAIL R1 masked value=%h exp=00", y_val & y_xm);
      end
    end
  end

  // Watchdog.
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog cycles=%0d exp<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    a_val = '0; a_xm = '0; b_val = '0; b_xm = '0; op = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset-time state with all-zero inputs: AND of zeros, rails consistent.
    checks++;
    if (y_val !== '0 || y_xm !== '0 || enc_ok !== 1'b1) begin
      fails++;
      $display("FAIL R2 idle val=%h/%h ok=%b exp=00/00 ok=1", y_val, y_xm, enc_ok);
    end
    // R2: defined 0 beats unknown; defined 1 beats unknown for OR.
    apply(0, 8'h00, 8'h0F, 6'h00, 6'h30, "R2");
    apply(1, 8'hFF, 8'h0F, 6'h3F, 6'h30, "R2");
    apply(0, 8'hFF, 8'h01, 6'h3F, 6'h00, "R2");
    // R3: unknown in either side makes the position unknown.
    apply(2, 8'hA5, 8'h10, 6'h0F, 6'h01, "R3");
    apply(3, 8'h3C, 8'h00, 6'h33, 6'h00, "R3");
    // R4 reductions.
    apply(4, 8'hFE, 8'h01, 6'h00, 6'h00, "R4");
    apply(4, 8'hFF, 8'h01, 6'h00, 6'h00, "R4");
    apply(5, 8'h00, 8'h80, 6'h00, 6'h00, "R4");
    apply(5, 8'h00, 8'h00, 6'h00, 6'h00, "R4");
    // R5 parity.
    apply(6, 8'h07, 8'h00, 6'h00, 6'h00, "R5");
    apply(6, 8'h07, 8'h40, 6'h00, 6'h00, "R5");
    // R6 logical.
    apply(7, 8'h00, 8'h00, 6'h00, 6'h3F, "R6");
    apply(8, 8'h01, 8'h00, 6'h00, 6'h3F, "R6");
    apply(7, 8'h00, 8'h02, 6'h04, 6'h00, "R6");
    // R7: definite mismatch beside unknown gives 0.
    apply(9, 8'h01, 8'h02, 6'h00, 6'h00, "R7");
    apply(9, 8'h01, 8'h02, 6'h01, 6'h00, "R7");
    apply(10, 8'h05, 8'h00, 6'h05, 6'h00, "R7");
    // R8: unknown matches unknown.
    apply(11, 8'h0A, 8'hF0, 6'h2A, 6'h30, "R8");
    apply(11, 8'h0A, 8'h0F, 6'h0A, 6'h0F, "R8");
    // R9: A upper bits set vs narrow B.
    apply(9, 8'hC0, 8'h00, 6'h00, 6'h00, "R9");
    apply(11, 8'h3F, 8'h00, 6'h3F, 6'h00, "R9");
    // R10 undefined opcodes.
    apply(12, 8'h55, 8'h00, 6'h15, 6'h00, "R10");
    apply(15, 8'hFF, 8'hFF, 6'h3F, 6'h3F, "R10");
    // R1: value bits under mask must not matter.
    apply(0, 8'hFF, 8'hF0, 6'h3F, 6'h00, "R1");
    apply(0, 8'h0F, 8'hF0, 6'h3F, 6'h00, "R1");
    apply(9, 8'hAA, 8'hFF, 6'h15, 6'h3F, "R1");
    // Sweep of pseudo-random operands over all opcodes.
    for (int n = 0; n < 1200; n++) begin
      logic [W-1:0] ra, rma;
      logic [BW-1:0] rb, rmb;
      ra  = W'($urandom);
      rb  = BW'($urandom);
      rma = (n % 3 == 0) ? W'($urandom) : (W'($urandom) & W'($urandom) & W'($urandom));
      rmb = (n % 4 == 0) ? '0 : (BW'($urandom) & BW'($urandom));
      apply(n % 16, ra, rma, rb, rmb, "");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule